// File: doc/BRIEF.md
# CPU Hold-and-Load Debug Controller

This controller sits between a small soft processor core, the memory the core uses, the write port of its register file and a serial transmit line. After reset it holds the core idle. While the core is held, a debug port owns both the memory port and the register-file write port. The debug port uses them to preload program words and initial register values, such as the stack pointer in register index 2. A one-cycle start pulse releases the core. The controller then raises the run level and gives a one-cycle load pulse with the start address, so that the core's first fetch comes from that address. From that point the core owns the memory and register-file ports. When the program has finished, a reset puts the core back into hold. The memory contents are not touched by reset, so results can be read back through the debug port.

The controller also owns the serial TX multiplexer. Out of reset the line carries the core's own transmitter. When the host delivers a valid debug frame, the line moves to the debug side and stays there until the next reset.

The debug memory request is a valid/ready stream. The two enables act as valid, and `dbg_mem_ready` is high only in hold. A request presented while ready is low is dropped, not queued, so the host must keep requests for the hold period. The read response is valid-only with no back-pressure: `dbg_mem_rvalid` lasts one cycle and the host must take the word in that cycle.

Top module: `hl_debug_ctrl`

## Requirements
- R1: After reset `core_run` and `core_pc_load` are 0 and `mem_owner_dbg` is 1 (hold state).
- R2: After reset `tx` equals `core_tx`.
- R3: In the cycle after a `dbg_frame_valid` pulse, and in every cycle after that until reset, `tx` equals `dbg_tx`.
- R4: In hold, a debug write (`dbg_mem_we`=1) drives `mem_en`=1, `mem_we`=1, `mem_addr`=`dbg_mem_addr` and `mem_wdata`=`dbg_mem_wdata` in the same cycle. `dbg_mem_ready` is 1.
- R5: In hold, a debug read (`dbg_mem_re`=1 with `dbg_mem_we`=0) gives `dbg_mem_rvalid`=1 one cycle later. In that cycle `dbg_mem_rdata` is the word stored at the address. In all other cycles `dbg_mem_rdata` is 0. If both enables are high, the write wins and no response is given.
- R6: In hold, a debug register write to index k drives `rf_idx`=k and `rf_data` in the same cycle, with `rf_we`=1 for k≠0. `rf_we` is never 1 with `rf_idx`=0.
- R7: A `start` pulse in hold makes `core_run`=1 from the next cycle. In that next cycle only, `core_pc_load`=1. `core_start_pc` holds the value `start_addr` had during the pulse.
- R8: A `start` pulse while running gives no `core_pc_load` and leaves `core_start_pc` unchanged.
- R9: While running, `dbg_mem_ready`=0 and `mem_owner_dbg`=0. Debug memory requests do not reach the memory port and produce no `dbg_mem_rvalid`, and `dbg_mem_rdata` stays 0. The memory port follows the core's request signals.
- R10: While running, debug register writes are ignored and the register-file port follows the core's write signals.
- R11: Reset returns the controller to hold. Words written before the reset, by either side, read back through the debug port.
- R12: In hold, core memory requests and core register writes do not reach their ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, enters hold |
| start | input | 1 | One-cycle release pulse |
| start_addr | input | AW | First fetch address, sampled on start |
| dbg_frame_valid | input | 1 | Host debug frame accepted; claims TX |
| dbg_reg_we | input | 1 | Debug register write enable |
| dbg_reg_idx | input | RIW | Debug register index |
| dbg_reg_data | input | DW | Debug register value |
| dbg_mem_re | input | 1 | Debug memory read request (valid) |
| dbg_mem_we | input | 1 | Debug memory write request (valid) |
| dbg_mem_addr | input | AW | Debug word address |
| dbg_mem_wdata | input | DW | Debug write word |
| dbg_mem_ready | output | 1 | Debug requests accepted (hold only) |
| dbg_mem_rdata | output | DW | Debug read word, zero when not valid |
| dbg_mem_rvalid | output | 1 | Debug read response strobe |
| core_mem_en | input | 1 | Core memory request |
| core_mem_we | input | 1 | Core memory write |
| core_mem_addr | input | AW | Core word address |
| core_mem_wdata | input | DW | Core write word |
| core_rf_we | input | 1 | Core register write enable |
| core_rf_idx | input | RIW | Core register index |
| core_rf_data | input | DW | Core register value |
| core_tx | input | 1 | Core serial transmitter output |
| dbg_tx | input | 1 | Debug-side serial transmitter output |
| core_run | output | 1 | Core may execute |
| core_pc_load | output | 1 | Load `core_start_pc` into the fetch counter |
| core_start_pc | output | AW | Latched start address |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, one cycle after enable |
| mem_owner_dbg | output | 1 | Memory port owned by the debug side |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | RIW | Register-file write index |
| rf_data | output | DW | Register-file write value |
| tx | output | 1 | Serial TX line |

## Verification
The bench writes a computed pattern to every word of a 64-word memory model and reads each word back. A controller that got the read timing wrong would strobe `dbg_mem_rvalid` in the wrong cycle or pass stale data. One that leaked the read bus would show nonzero `dbg_mem_rdata` when no response is due. The bench sweeps every register index and catches a write to index 0, or a dropped write to index 1. Start pulses given while running would move the start address or re-pulse the load. After a frame-valid pulse, a TX select that is not sticky would hand the line back to the core. Debug writes made while running are read back after reset to show they never reached memory. A core write made while running is read back the same way, so a controller that blocked the core while running would fail.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;
endpackage

// File: rtl/hl_run_ctrl.sv
module hl_run_ctrl
  import hl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          hold,
  output logic          core_run,
  output logic          core_pc_load,
  output logic [AW-1:0] core_start_pc
);
  run_st_e       st_q;
  logic          load_q;
  logic [AW-1:0] pc_q;
  logic          go;

  assign go = (st_q == ST_HOLD) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      load_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      load_q <= go;
      if (go) begin
        st_q <= ST_RUN;
        pc_q <= start_addr;
      end
    end
  end

  assign hold          = (st_q == ST_HOLD);
  assign core_run      = (st_q == ST_RUN);
  assign core_pc_load  = load_q;
  assign core_start_pc = pc_q;

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && start) |=> (core_run && core_pc_load && core_start_pc == $past(start_addr)));
  p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> (!core_pc_load && $stable(core_start_pc) && core_run));
  p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !core_pc_load);
endmodule

// File: rtl/hl_tx_sel.sv
module hl_tx_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_frame_valid,
  input  logic core_tx,
  input  logic dbg_tx,
  output logic tx
);
  logic to_dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               to_dbg_q <= 1'b0;
    else if (dbg_frame_valid) to_dbg_q <= 1'b1;
  end

  assign tx = to_dbg_q ? dbg_tx : core_tx;

  p_tx_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_frame_valid |=> (tx == dbg_tx));
  p_tx_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    to_dbg_q |=> to_dbg_q);
endmodule

// File: rtl/hl_mem_port.sv
module hl_mem_port #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          dbg_mem_re,
  input  logic          dbg_mem_we,
  input  logic [AW-1:0] dbg_mem_addr,
  input  logic [DW-1:0] dbg_mem_wdata,
  output logic          dbg_mem_ready,
  output logic [DW-1:0] dbg_mem_rdata,
  output logic          dbg_mem_rvalid,
  input  logic          core_mem_en,
  input  logic          core_mem_we,
  input  logic [AW-1:0] core_mem_addr,
  input  logic [DW-1:0] core_mem_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic rd_take;
  logic rvalid_q;

  assign rd_take = hold && dbg_mem_re && !dbg_mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_take;
  end

  always_comb begin
    if (hold) begin
      mem_en    = dbg_mem_re || dbg_mem_we;
      mem_we    = dbg_mem_we;
      mem_addr  = dbg_mem_addr;
      mem_wdata = dbg_mem_wdata;
    end else begin
      mem_en    = core_mem_en;
      mem_we    = core_mem_en && core_mem_we;
      mem_addr  = core_mem_addr;
      mem_wdata = core_mem_wdata;
    end
  end

  assign dbg_mem_ready  = hold;
  assign dbg_mem_rvalid = rvalid_q;
  assign dbg_mem_rdata  = rvalid_q ? mem_rdata : '0;

  p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && dbg_mem_re && !dbg_mem_we) |=> dbg_mem_rvalid);
  p_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mem_rvalid |-> (dbg_mem_rdata == '0));
  p_run_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (dbg_mem_re || dbg_mem_we)) |-> !dbg_mem_ready);
  p_core_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !dbg_mem_re && !dbg_mem_we) |-> !mem_en);
endmodule

// File: rtl/hl_reg_gate.sv
module hl_reg_gate #(
  parameter int DW  = 32,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           dbg_reg_we,
  input  logic [RIW-1:0] dbg_reg_idx,
  input  logic [DW-1:0]  dbg_reg_data,
  input  logic           core_rf_we,
  input  logic [RIW-1:0] core_rf_idx,
  input  logic [DW-1:0]  core_rf_data,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_data
);
  logic sel_we;

  always_comb begin
    if (hold) begin
      sel_we  = dbg_reg_we;
      rf_idx  = dbg_reg_idx;
      rf_data = dbg_reg_data;
    end else begin
      sel_we  = core_rf_we;
      rf_idx  = core_rf_idx;
      rf_data = core_rf_data;
    end
  end

  assign rf_we = sel_we && (rf_idx != '0);

  p_no_x0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_idx != '0));
  p_run_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !core_rf_we) |-> !rf_we);
endmodule

// File: rtl/hl_debug_ctrl.sv
module hl_debug_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int NREG = 32,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic           dbg_frame_valid,
  input  logic           dbg_reg_we,
  input  logic [RIW-1:0] dbg_reg_idx,
  input  logic [DW-1:0]  dbg_reg_data,
  input  logic           dbg_mem_re,
  input  logic           dbg_mem_we,
  input  logic [AW-1:0]  dbg_mem_addr,
  input  logic [DW-1:0]  dbg_mem_wdata,
  output logic           dbg_mem_ready,
  output logic [DW-1:0]  dbg_mem_rdata,
  output logic           dbg_mem_rvalid,
  input  logic           core_mem_en,
  input  logic           core_mem_we,
  input  logic [AW-1:0]  core_mem_addr,
  input  logic [DW-1:0]  core_mem_wdata,
  input  logic           core_rf_we,
  input  logic [RIW-1:0] core_rf_idx,
  input  logic [DW-1:0]  core_rf_data,
  input  logic           core_tx,
  input  logic           dbg_tx,
  output logic           core_run,
  output logic           core_pc_load,
  output logic [AW-1:0]  core_start_pc,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic           mem_owner_dbg,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_data,
  output logic           tx
);
  logic hold;

  hl_run_ctrl #(.AW(AW)) u_run (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .hold(hold), .core_run(core_run), .core_pc_load(core_pc_load),
    .core_start_pc(core_start_pc)
  );

  hl_tx_sel u_tx (
    .clk(clk), .rst_n(rst_n), .dbg_frame_valid(dbg_frame_valid),
    .core_tx(core_tx), .dbg_tx(dbg_tx), .tx(tx)
  );

  hl_mem_port #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .dbg_mem_re(dbg_mem_re), .dbg_mem_we(dbg_mem_we),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_wdata(dbg_mem_wdata),
    .dbg_mem_ready(dbg_mem_ready), .dbg_mem_rdata(dbg_mem_rdata),
    .dbg_mem_rvalid(dbg_mem_rvalid),
    .core_mem_en(core_mem_en), .core_mem_we(core_mem_we),
    .core_mem_addr(core_mem_addr), .core_mem_wdata(core_mem_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  hl_reg_gate #(.DW(DW), .RIW(RIW)) u_reg (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .dbg_reg_we(dbg_reg_we), .dbg_reg_idx(dbg_reg_idx), .dbg_reg_data(dbg_reg_data),
    .core_rf_we(core_rf_we), .core_rf_idx(core_rf_idx), .core_rf_data(core_rf_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  assign mem_owner_dbg = hold;

  p_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_owner_dbg |-> !core_run);
endmodule

// File: tb/hl_debug_ctrl_tb.sv
module hl_debug_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, dbg_frame_valid = 0, dbg_reg_we = 0;
  logic [AW-1:0] start_addr = '0;
  logic [4:0] dbg_reg_idx = '0;
  logic [DW-1:0] dbg_reg_data = '0;
  logic dbg_mem_re = 0, dbg_mem_we = 0;
  logic [AW-1:0] dbg_mem_addr = '0;
  logic [DW-1:0] dbg_mem_wdata = '0;
  logic dbg_mem_ready, dbg_mem_rvalid;
  logic [DW-1:0] dbg_mem_rdata;
  logic core_mem_en = 0, core_mem_we = 0;
  logic [AW-1:0] core_mem_addr = '0;
  logic [DW-1:0] core_mem_wdata = '0;
  logic core_rf_we = 0;
  logic [4:0] core_rf_idx = '0;
  logic [DW-1:0] core_rf_data = '0;
  logic core_tx = 1, dbg_tx = 1;
  logic core_run, core_pc_load, mem_en, mem_we, mem_owner_dbg, rf_we, tx;
  logic [AW-1:0] core_start_pc, mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [4:0] rf_idx;
  logic [DW-1:0] rf_data;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      rd_q <= mem[mem_addr[5:0]];
    end
  end
  assign mem_rdata = rd_q;

  hl_debug_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .dbg_frame_valid(dbg_frame_valid), .dbg_reg_we(dbg_reg_we),
    .dbg_reg_idx(dbg_reg_idx), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_re(dbg_mem_re), .dbg_mem_we(dbg_mem_we),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_wdata(dbg_mem_wdata),
    .dbg_mem_ready(dbg_mem_ready), .dbg_mem_rdata(dbg_mem_rdata),
    .dbg_mem_rvalid(dbg_mem_rvalid),
    .core_mem_en(core_mem_en), .core_mem_we(core_mem_we),
    .core_mem_addr(core_mem_addr), .core_mem_wdata(core_mem_wdata),
    .core_rf_we(core_rf_we), .core_rf_idx(core_rf_idx), .core_rf_data(core_rf_data),
    .core_tx(core_tx), .dbg_tx(dbg_tx),
    .core_run(core_run), .core_pc_load(core_pc_load), .core_start_pc(core_start_pc),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_owner_dbg(mem_owner_dbg),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .tx(tx)
  );

  function automatic logic [DW-1:0] pat(int i);
    return (i * 32'h9E37_79B1) ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance to next negedge, then settle
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic dbg_write(int a, logic [DW-1:0] d);
    dbg_mem_we = 1; dbg_mem_addr = AW'(a); dbg_mem_wdata = d;
    #1;
    chk("R4 mem_en", DW'(mem_en), 1);
    chk("R4 mem_we", DW'(mem_we), 1);
    chk("R4 addr", DW'(mem_addr), DW'(a));
    chk("R4 data", mem_wdata, d);
    step();
    dbg_mem_we = 0;
  endtask

  task automatic dbg_read(int a, logic [DW-1:0] exp, string req);
    dbg_mem_re = 1; dbg_mem_addr = AW'(a);
    #1;
    chk({req, " no early rvalid"}, DW'(dbg_mem_rvalid), 0);
    step();
    dbg_mem_re = 0;
    #1;
    chk({req, " rvalid"}, DW'(dbg_mem_rvalid), 1);
    chk({req, " rdata"}, dbg_mem_rdata, exp);
    step();
    chk({req, " rvalid drop"}, DW'(dbg_mem_rvalid), 0);
    chk({req, " rdata zero"}, dbg_mem_rdata, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    step();
    rst_n = 1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 core_run", DW'(core_run), 0);
    chk("R1 pc_load", DW'(core_pc_load), 0);
    chk("R1 owner", DW'(mem_owner_dbg), 1);
    chk("R4 ready in hold", DW'(dbg_mem_ready), 1);
    // R2 tx follows core
    for (int b = 0; b < 4; b++) begin
      core_tx = b[0]; dbg_tx = b[1];
      #1;
      chk("R2 tx core", DW'(tx), DW'(b[0]));
    end
    // R12 core blocked in hold
    core_mem_en = 1; core_mem_we = 1; core_mem_addr = 16'd9; core_mem_wdata = 32'hDEAD_BEEF;
    core_rf_we = 1; core_rf_idx = 5'd4; core_rf_data = 32'h1234;
    #1;
    chk("R12 mem_en blocked", DW'(mem_en), 0);
    chk("R12 rf_we blocked", DW'(rf_we), 0);
    step();
    core_mem_en = 0; core_mem_we = 0; core_rf_we = 0;
    // R4/R5 sweep
    for (int i = 0; i < NW; i++) dbg_write(i, pat(i));
    for (int i = 0; i < NW; i++) dbg_read(i, pat(i), "R5");
    // R5 both enables: write wins, no response
    dbg_mem_re = 1; dbg_mem_we = 1; dbg_mem_addr = 16'd3; dbg_mem_wdata = 32'h0BAD_F00D;
    step();
    dbg_mem_re = 0; dbg_mem_we = 0;
    #1;
    chk("R5 both no rvalid", DW'(dbg_mem_rvalid), 0);
    dbg_read(3, 32'h0BAD_F00D, "R5 both write");
    // R6 register sweep
    for (int k = 0; k < 32; k++) begin
      dbg_reg_we = 1; dbg_reg_idx = 5'(k); dbg_reg_data = k * 32'h1111_1111;
      #1;
      chk("R6 rf_we", DW'(rf_we), DW'(k != 0));
      chk("R6 rf_idx", DW'(rf_idx), DW'(k));
      chk("R6 rf_data", rf_data, k * 32'h1111_1111);
      step();
    end
    dbg_reg_we = 0;
    // R3 switch tx
    dbg_frame_valid = 1;
    step();
    dbg_frame_valid = 0;
    for (int b = 0; b < 4; b++) begin
      core_tx = b[0]; dbg_tx = b[1];
      #1;
      chk("R3 tx dbg", DW'(tx), DW'(b[1]));
      step();
    end
    // R7 start
    start = 1; start_addr = 16'h8000;
    step();
    start = 0; start_addr = 16'h1111;
    chk("R7 run", DW'(core_run), 1);
    chk("R7 pc_load", DW'(core_pc_load), 1);
    chk("R7 start_pc", DW'(core_start_pc), 32'h8000);
    step();
    chk("R7 pc_load one cycle", DW'(core_pc_load), 0);
    // R8 start while running
    start = 1; start_addr = 16'h2222;
    step();
    start = 0;
    chk("R8 no reload", DW'(core_pc_load), 0);
    chk("R8 pc kept", DW'(core_start_pc), 32'h8000);
    step();
    chk("R8 still running", DW'(core_run), 1);
    // R9 debug memory ignored while running
    chk("R9 ready low", DW'(dbg_mem_ready), 0);
    chk("R9 owner", DW'(mem_owner_dbg), 0);
    dbg_mem_we = 1; dbg_mem_addr = 16'd5; dbg_mem_wdata = 32'hFFFF_0000;
    #1;
    chk("R9 dbg write blocked", DW'(mem_en), 0);
    step();
    dbg_mem_we = 0; dbg_mem_re = 1; dbg_mem_addr = 16'd6;
    step();
    dbg_mem_re = 0;
    chk("R9 no rvalid", DW'(dbg_mem_rvalid), 0);
    chk("R9 rdata zero", dbg_mem_rdata, 0);
    // R9 core owns port
    core_mem_en = 1; core_mem_we = 1; core_mem_addr = 16'd7; core_mem_wdata = 32'hCAFE_0007;
    #1;
    chk("R9 core en", DW'(mem_en), 1);
    chk("R9 core addr", DW'(mem_addr), 7);
    chk("R9 core data", mem_wdata, 32'hCAFE_0007);
    step();
    core_mem_en = 0; core_mem_we = 0;
    // R10 reg port
    dbg_reg_we = 1; dbg_reg_idx = 5'd2; dbg_reg_data = 32'h5555;
    #1;
    chk("R10 dbg reg ignored", DW'(rf_we), 0);
    core_rf_we = 1; core_rf_idx = 5'd3; core_rf_data = 32'h7777;
    #1;
    chk("R10 core we", DW'(rf_we), 1);
    chk("R10 core idx", DW'(rf_idx), 3);
    chk("R10 core data", rf_data, 32'h7777);
    step();
    dbg_reg_we = 0; core_rf_we = 0;
    // R11 reset back to hold, results readable
    do_reset();
    chk("R11 hold", DW'(core_run), 0);
    chk("R11 owner", DW'(mem_owner_dbg), 1);
    core_tx = 0; dbg_tx = 1;
    #1;
    chk("R2 tx back to core", DW'(tx), 0);
    dbg_read(5, pat(5), "R11 untouched");
    dbg_read(7, 32'hCAFE_0007, "R11 core write");
    dbg_read(40, pat(40), "R11 kept");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule